// File: doc/BRIEF.md
# Video DMA Cycle-Steal Scheduler

This block decides, for every bus cycle of a shared processor/video bus, who owns the bus. It keeps a raster position made of a cycle-in-line counter and a line counter. A mode input selects one of three frame geometries. On character-fetch lines the block first lowers a bus-request line to warn the processor. Three cycles later it hands the bus to the video side for the forty character fetches. Each enabled sprite adds two more stolen cycles directly after that window. The warning lead exists because the processor can only be halted on a read, and up to three writes can occur back to back (an interrupt entry pushes a return address and status).

The processor-ready output follows the request line. A frame tally counts the cycles left to the processor. It latches that count when the frame wraps, so software-free checks of throughput are possible. Examples are 18581 cycles per 63×312 frame and 15955 per 65×262 frame with sprites off.

The scheduler is a three-state machine. In `ST_RUN` the processor owns the bus. In `ST_WARN` the request is low but the processor still drives the bus. In `ST_STEAL` the video side owns the bus. The transitions are RUN→WARN when the next cycle is the warning point, WARN→STEAL when the next cycle is the first stolen cycle, and STEAL→RUN when the next cycle is the end of the window.

Top module: `vdma_steal_sched`

## Requirements
- R1: The cycle counter runs 0..L-1 and the line counter runs 0..N-1, wrapping together. `geom` = 0 gives L=63, N=312; `geom` = 1 gives L=64, N=262; `geom` = 2 or 3 gives L=65, N=262.
- R2: A line is a character-fetch line when `disp_en` is 1, the line number lies in 48..247 inclusive, and the line number's low three bits equal `vscroll`. This gives 25 such lines per frame.
- R3: On a character-fetch line, the video side owns the bus in cycles 6..45 plus the sprite cycles. `bus_req_n` is low from cycle 3 to the end of that window, so it falls exactly three cycles before ownership changes.
- R4: With n enabled sprites, the stolen window ends at cycle 46+2n, exclusive. On a line that is not a character-fetch line but has n>0, `bus_req_n` is low from cycle 43 and the video side owns the bus from cycle 46, both up to 46+2n. A line with neither steals nothing.
- R5: `cpu_owns` is low only while `bus_req_n` is low. At the end of a window both return high in the same cycle.
- R6: `cpu_ready` equals `bus_req_n` in every cycle.
- R7: `sprite_en` and the fetch-line decision are sampled as the line starts. A change in mid-line affects only the following line.
- R8: `frame_tick` is high for exactly the first cycle of each new frame. At that point `cpu_cycles` holds the number of cycles in the previous frame with `bus_req_n` high: 18581 for geom 0 and 15955 for geom 2, with no sprites and `disp_en` set.
- R9: During reset, `bus_req_n`, `cpu_owns` and `cpu_ready` are 1, the raster position is (0,0), `frame_tick` is 0 and `cpu_cycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| geom | input | 2 | Frame geometry select |
| disp_en | input | 1 | Display enable for character fetches |
| vscroll | input | 3 | Vertical fine scroll, matched against line low bits |
| sprite_en | input | 8 | Per-sprite enable mask |
| bus_req_n | output | 1 | Low warns the processor that a steal is coming or active |
| cpu_owns | output | 1 | High when the processor owns the bus, low when video does |
| cpu_ready | output | 1 | Processor ready |
| raster_x | output | 7 | Cycle within line |
| raster_y | output | 9 | Line within frame |
| frame_tick | output | 1 | First cycle of a new frame |
| cpu_cycles | output | 16 | Processor cycles counted over the last full frame |

## Verification
On every cycle, the assertions check the shape of each steal. A falling request is followed by exactly three cycles of processor ownership and then a handover. Video ownership never appears without the request. Request and ownership are released together. They also check that a frame tick only falls at raster origin, and that the raster stays in range. Only the bench's frame sweeps can show the window positions, the per-line sampling of the sprite mask and the per-frame cycle totals. These sweeps compare every cycle of a full frame in each of four geometry and sprite configurations against an arithmetic model, including a mask that flips in mid-line.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_WARN,
        ST_STEAL
    } steal_state_t;
endpackage

// File: rtl/vdma_raster_ctr.sv
module vdma_raster_ctr #(
    parameter int XW     = 7,
    parameter int YW     = 9,
    parameter int G0_CYC = 63,
    parameter int G0_LIN = 312,
    parameter int G1_CYC = 64,
    parameter int G1_LIN = 262,
    parameter int G2_CYC = 65,
    parameter int G2_LIN = 262
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    geom,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic [XW-1:0] x_nxt,
    output logic [YW-1:0] y_nxt,
    output logic          frame_last
);
    logic [XW-1:0] len;
    logic [YW-1:0] lines;
    logic          x_last;
    logic          y_last;

    always_comb begin
        unique case (geom)
            2'd0:    begin len = XW'(G0_CYC); lines = YW'(G0_LIN); end
            2'd1:    begin len = XW'(G1_CYC); lines = YW'(G1_LIN); end
            default: begin len = XW'(G2_CYC); lines = YW'(G2_LIN); end
        endcase
    end

    assign x_last     = (x >= len - XW'(1));
    assign y_last     = (y >= lines - YW'(1));
    assign x_nxt      = x_last ? '0 : x + XW'(1);
    assign y_nxt      = x_last ? (y_last ? '0 : y + YW'(1)) : y;
    assign frame_last = x_last && y_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else begin
            x <= x_nxt;
            y <= y_nxt;
        end
    end
endmodule

// File: rtl/vdma_steal_fsm.sv
module vdma_steal_fsm
    import vdma_pkg::*;
#(
    parameter int XW        = 7,
    parameter int YW        = 9,
    parameter int NSPR      = 8,
    parameter int SCW       = 3,
    parameter int FETCH_AT  = 6,
    parameter int FETCH_LEN = 40,
    parameter int LEAD      = 3,
    parameter int WIN_TOP   = 48,
    parameter int WIN_BOT   = 247
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XW-1:0]   x_nxt,
    input  logic [YW-1:0]   y_nxt,
    input  logic            disp_en,
    input  logic [SCW-1:0]  vscroll,
    input  logic [NSPR-1:0] sprite_en,
    output logic            req_n,
    output logic            owns
);
    localparam int NCW = $clog2(NSPR + 1);

    steal_state_t  state, state_nx;
    logic          fetch_q;
    logic [NCW-1:0] nspr_q;
    logic [NCW-1:0] nspr_in;
    logic          fetch_in;
    logic          steal_line;
    logic [XW-1:0] win_start;
    logic [XW-1:0] win_stop;
    logic [XW-1:0] warn_at;

    always_comb begin
        nspr_in = '0;
        for (int i = 0; i < NSPR; i++) begin
            nspr_in = nspr_in + NCW'(sprite_en[i]);
        end
    end

    assign fetch_in = disp_en
                   && (y_nxt >= YW'(WIN_TOP)) && (y_nxt <= YW'(WIN_BOT))
                   && (y_nxt[SCW-1:0] == vscroll);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= 1'b0;
            nspr_q  <= '0;
        end else if (x_nxt == '0) begin
            fetch_q <= fetch_in;
            nspr_q  <= nspr_in;
        end
    end

    assign steal_line = fetch_q || (nspr_q != '0);
    assign win_start  = fetch_q ? XW'(FETCH_AT) : XW'(FETCH_AT + FETCH_LEN);
    assign win_stop   = XW'(FETCH_AT + FETCH_LEN) + XW'({nspr_q, 1'b0});
    assign warn_at    = win_start - XW'(LEAD);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (steal_line && x_nxt == warn_at) state_nx = ST_WARN;
            ST_WARN:  if (x_nxt == win_start)             state_nx = ST_STEAL;
            ST_STEAL: if (x_nxt == win_stop)              state_nx = ST_RUN;
            default:                                      state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        req_n = 1'b1;
        owns  = 1'b1;
        unique case (state)
            ST_RUN:   begin req_n = 1'b1; owns = 1'b1; end
            ST_WARN:  begin req_n = 1'b0; owns = 1'b1; end
            ST_STEAL: begin req_n = 1'b0; owns = 1'b0; end
            default:  begin req_n = 1'b1; owns = 1'b1; end
        endcase
    end
endmodule

// File: rtl/vdma_frame_tally.sv
module vdma_frame_tally #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_cycle,
    input  logic          frame_last,
    output logic [CW-1:0] total,
    output logic          tick
);
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            total   <= '0;
            tick    <= 1'b0;
        end else if (frame_last) begin
            total   <= run_cnt + CW'(cpu_cycle);
            run_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            run_cnt <= run_cnt + CW'(cpu_cycle);
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/vdma_steal_sched.sv
module vdma_steal_sched #(
    parameter int XW   = 7,
    parameter int YW   = 9,
    parameter int CW   = 16,
    parameter int NSPR = 8,
    parameter int SCW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      geom,
    input  logic            disp_en,
    input  logic [SCW-1:0]  vscroll,
    input  logic [NSPR-1:0] sprite_en,
    output logic            bus_req_n,
    output logic            cpu_owns,
    output logic            cpu_ready,
    output logic [XW-1:0]   raster_x,
    output logic [YW-1:0]   raster_y,
    output logic            frame_tick,
    output logic [CW-1:0]   cpu_cycles
);
    logic [XW-1:0] x_nxt;
    logic [YW-1:0] y_nxt;
    logic          frame_last;

    vdma_raster_ctr #(.XW(XW), .YW(YW)) u_raster (
        .clk        (clk),
        .rst_n      (rst_n),
        .geom       (geom),
        .x          (raster_x),
        .y          (raster_y),
        .x_nxt      (x_nxt),
        .y_nxt      (y_nxt),
        .frame_last (frame_last)
    );

    vdma_steal_fsm #(.XW(XW), .YW(YW), .NSPR(NSPR), .SCW(SCW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .x_nxt     (x_nxt),
        .y_nxt     (y_nxt),
        .disp_en   (disp_en),
        .vscroll   (vscroll),
        .sprite_en (sprite_en),
        .req_n     (bus_req_n),
        .owns      (cpu_owns)
    );

    vdma_frame_tally #(.CW(CW)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_cycle  (bus_req_n),
        .frame_last (frame_last),
        .total      (cpu_cycles),
        .tick       (frame_tick)
    );

    assign cpu_ready = bus_req_n;
endmodule

// File: rtl/vdma_steal_sched_chk.sv
module vdma_steal_sched_chk #(
    parameter int XW    = 7,
    parameter int YW    = 9,
    parameter int MAX_X = 65,
    parameter int MAX_Y = 312
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req_n,
    input logic          cpu_owns,
    input logic          cpu_ready,
    input logic [XW-1:0] raster_x,
    input logic [YW-1:0] raster_y,
    input logic          frame_tick
);
    AST_X_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        raster_x < XW'(MAX_X)); // R1
    AST_Y_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        raster_y < YW'(MAX_Y)); // R1
    AST_WARN_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_n) |-> cpu_owns ##1 cpu_owns ##1 cpu_owns ##1 !cpu_owns); // R3
    AST_OWN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_owns |-> !bus_req_n); // R5
    AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_n) |-> $rose(cpu_owns)); // R5
    AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ready) |-> bus_req_n); // R6
    AST_TICK_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> (raster_x == '0 && raster_y == '0)); // R8
    AST_LINE_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (raster_x == '0) |-> bus_req_n); // R4
endmodule

bind vdma_steal_sched vdma_steal_sched_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req_n  (bus_req_n),
    .cpu_owns   (cpu_owns),
    .cpu_ready  (cpu_ready),
    .raster_x   (raster_x),
    .raster_y   (raster_y),
    .frame_tick (frame_tick)
);

// File: tb/vdma_steal_sched_bench.sv
module vdma_steal_sched_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  geom = 2'd0;
    logic        disp_en = 1'b0;
    logic [2:0]  vscroll = 3'd0;
    logic [7:0]  sprite_en = 8'h00;
    logic        bus_req_n, cpu_owns, cpu_ready, frame_tick;
    logic [6:0]  raster_x;
    logic [8:0]  raster_y;
    logic [15:0] cpu_cycles;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vdma_steal_sched u_vdma_steal_sched (
        .clk(clk), .rst_n(rst_n), .geom(geom), .disp_en(disp_en),
        .vscroll(vscroll), .sprite_en(sprite_en), .bus_req_n(bus_req_n),
        .cpu_owns(cpu_owns), .cpu_ready(cpu_ready), .raster_x(raster_x),
        .raster_y(raster_y), .frame_tick(frame_tick), .cpu_cycles(cpu_cycles)
    );

    function automatic int popc(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cfg(input logic [1:0] g, input logic d, input logic [2:0] ys,
                           input logic [7:0] sp, input bit toggle, input int exp_total);
        int len, lines, ex, ey, acc, n, ss, se;
        bit chk, fin, bad, steal, ba_e, aec_e;
        logic [7:0] lmask;
        @(negedge clk);
        rst_n = 1'b0; geom = g; disp_en = d; vscroll = ys; sprite_en = sp;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(bus_req_n && cpu_owns && cpu_ready, "R9 outputs", {bus_req_n, cpu_owns, cpu_ready}, 7);
        check(raster_x == 0 && raster_y == 0 && !frame_tick && cpu_cycles == 0,
              "R9 raster/tally", int'(cpu_cycles), 0);
        len   = (g == 2'd0) ? 63 : (g == 2'd1) ? 64 : 65;
        lines = (g == 2'd0) ? 312 : 262;
        rst_n = 1'b1;
        ex = 0; ey = 0; acc = 0; chk = 0; fin = 0; lmask = 8'h00;
        while (!fin) begin
            @(negedge clk);
            ex++;
            if (ex == len) begin ex = 0; ey = (ey == lines - 1) ? 0 : ey + 1; end
            if (ex == 0) lmask = sprite_en;  // R7 model: mask taken at line start
            check(int'(raster_x) == ex && int'(raster_y) == ey, "R1 position",
                  int'(raster_x) * 1000 + int'(raster_y), ex * 1000 + ey);
            check(frame_tick == (ex == 0 && ey == 0), "R8 frame_tick", int'(frame_tick),
                  int'(ex == 0 && ey == 0));
            if (ex == 0 && ey == 0) begin
                if (chk) begin
                    check(int'(cpu_cycles) == acc, "R8 frame total", int'(cpu_cycles), acc);
                    if (exp_total >= 0)
                        check(int'(cpu_cycles) == exp_total, "R8 frame constant",
                              int'(cpu_cycles), exp_total);
                    fin = 1;
                end
                chk = 1;
            end
            if (chk && !fin) begin
                bad   = d && ey >= 48 && ey <= 247 && (ey % 8) == int'(ys);
                n     = popc(lmask);
                steal = bad || n > 0;
                ss    = bad ? 6 : 46;
                se    = 46 + 2 * n;
                ba_e  = !(steal && ex >= ss - 3 && ex < se);
                aec_e = !(steal && ex >= ss && ex < se);
                acc  += int'(ba_e);
                check(bus_req_n == ba_e, bad ? "R2/R3/R7 request" : "R4/R7 request",
                      int'(bus_req_n), int'(ba_e));
                check(cpu_owns == aec_e, "R3/R4/R5 ownership", int'(cpu_owns), int'(aec_e));
                check(cpu_ready == ba_e, "R6 ready", int'(cpu_ready), int'(ba_e));
                if (toggle && ex == 30) sprite_en = ~sprite_en;  // R7 mid-line change
            end
        end
    endtask

    initial begin
        // geom 0, no sprites: 63*312 - 25*43
        run_cfg(2'd0, 1'b1, 3'd3, 8'h00, 1'b0, 18581);
        // geom 2, no sprites: 65*262 - 25*43
        run_cfg(2'd2, 1'b1, 3'd0, 8'h00, 1'b0, 15955);
        // geom 1, mask flipping between none and all in mid-line
        run_cfg(2'd1, 1'b1, 3'd5, 8'h00, 1'b1, -1);
        // geom 1, display off, two sprites: 64*262 - 262*(3+4)
        run_cfg(2'd1, 1'b0, 3'd2, 8'h81, 1'b0, 14934);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule